// File: doc/BRIEF.md
# Grouped Interrupt Pending Bank

This block gathers interrupt events from a bank of general-purpose pins and holds them as pending bits. Each pending bit is stored per interrupt group and per pin. Every pin carries a 3-bit trigger mode and a 3-bit group field, both driven in from the pin configuration registers. The block watches each pin's sampled level and turns it into an event according to the mode. The event then sets the pending bit of that pin only in the group its group field currently names. One interrupt line per group leaves the block. A line is high while any bit of its group is pending.

Software reaches the pending bits through the same word-wide register interface that serves the pin bank. The block answers only in an upper address window. Each group occupies a 64-byte slice of that window. Each 32-bit word in a slice covers 32 consecutive pins. A service routine reads a group's words one by one. It acknowledges each set bit by writing a word that has a one in that bit's position.

Because the group field is part of the pending index, software can move a pin to another interrupt line by rewriting that field. Bits that are already pending stay in the group where they were raised.

Top module: `irqb_bank`

## Requirements
- R1: After reset, every pending bit is 0, every `irq_out` line is 0 and `bus_rdata` is 0.
- R2: The pending word for group g covering pins 32k to 32k+31 is at byte address BASE + 0x40·g + 4·k, where BASE is 0x800. Pin 32k+i sits in bit i of that word. Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R3: A pin's event sets that pin's pending bit only in the group equal to its 3-bit group field, and in no other group.
- R4: The trigger mode codes are as follows. Code 2 is level high. Code 3 is level low. Code 4 is rising edge. Code 5 is falling edge. Code 6 is either edge. Codes 0, 1 and 7 never produce an event.
- R5: In a level mode, if the level condition still holds when the pending bit is cleared, the bit reads back as pending after the clear.
- R6: An edge is detected when a pin's level differs from its level at the previous clock edge. While the level is held steady, a cleared edge-mode bit stays clear.
- R7: A write clears every pending bit whose position holds a 1 in the written data. Bits whose position holds a 0 are unchanged, and a write of all zeros changes nothing.
- R8: If a pin's event and a write-1 clear of the same bit occur in the same cycle, the bit stays pending.
- R9: `irq_out[g]` is high exactly when at least one pending bit of group g is set.
- R10: The following accesses read 0 and have no effect when written. An address below BASE. An address at or beyond BASE + 0x40·NGRP. A misaligned address (low two bits not 00). A word index at or beyond the number of pin words. Bits for pins at or beyond NPINS are also 0.
- R11: After a pin's group field changes, new events of that pin set bits in the new group. A bit that was already pending in the old group stays pending there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NPINS | Synchronised input level of each pin |
| pin_mode | input | NPINS*3 | Trigger mode per pin, pin p in bits [3p+2:3p] |
| pin_grp | input | NPINS*3 | Interrupt group per pin, pin p in bits [3p+2:3p] |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data; ones acknowledge pending bits |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NGRP | One interrupt line per group |

## Verification
A level or edge that is present before clock edge N is pending, and visible on `irq_out`, just after edge N. A write-1 clear takes effect at the edge that accepts the write. A read returns the pending state as it stood before that edge, on `bus_rdata`, after the same edge. The bench drives all inputs at the falling edge and keeps a behavioural model that advances at each rising edge. It compares `irq_out` and `bus_rdata` at the following falling edge. Directed checks are sampled one falling edge after the stimulus, the first point at which its effect can show. For this reason, simultaneous event and clear, and group moves, are stimulated within a single cycle.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
   localparam int MODE_W = 3;
   localparam int GRP_W  = 3;
   localparam int WORD_W = 32;
   localparam int WIDX_W = 4;

   typedef enum logic [MODE_W-1:0] {
      TRIG_NONE  = 3'd0,
      TRIG_DRIVE = 3'd1,
      TRIG_HIGH  = 3'd2,
      TRIG_LOW   = 3'd3,
      TRIG_RISE  = 3'd4,
      TRIG_FALL  = 3'd5,
      TRIG_BOTH  = 3'd6,
      TRIG_OFF   = 3'd7
   } trig_mode_e;

   function automatic logic trig_hit(input logic [MODE_W-1:0] mode,
                                     input logic lvl, input logic prv);
      logic hit;
      case (mode)
         TRIG_HIGH: hit = lvl;
         TRIG_LOW:  hit = ~lvl;
         TRIG_RISE: hit = lvl & ~prv;
         TRIG_FALL: hit = ~lvl & prv;
         TRIG_BOTH: hit = lvl ^ prv;
         default:   hit = 1'b0;
      endcase
      return hit;
   endfunction
endpackage

// File: rtl/irqb_detect.sv
module irqb_detect
   import irqb_pkg::*;
#(
   parameter int NPINS = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPINS-1:0]        pin_level,
   input  logic [NPINS*MODE_W-1:0] pin_mode,
   output logic [NPINS-1:0]        pin_event
);
   logic [NPINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_level;
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign pin_event[p] = trig_hit(pin_mode[p*MODE_W +: MODE_W],
                                     pin_level[p], prev_q[p]);
   end
endmodule

// File: rtl/irqb_pend.sv
module irqb_pend
   import irqb_pkg::*;
#(
   parameter int NPINS = 64,
   parameter int NGRP  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPINS-1:0]       pin_event,
   input  logic [NPINS*GRP_W-1:0] pin_grp,
   input  logic                   clr_en,
   input  logic [GRP_W-1:0]       clr_grp,
   input  logic [WIDX_W-1:0]      clr_word,
   input  logic [WORD_W-1:0]      clr_bits,
   output logic [NGRP*NPINS-1:0]  pend_flat,
   output logic [NGRP-1:0]        irq_out
);
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         localparam int WIX = p / WORD_W;
         localparam int BIX = p % WORD_W;
         logic set_w, clr_w, bit_q;

         assign set_w = pin_event[p] && (pin_grp[p*GRP_W +: GRP_W] == GRP_W'(g));
         assign clr_w = clr_en && (clr_grp == GRP_W'(g)) &&
                        (clr_word == WIDX_W'(WIX)) && clr_bits[BIX];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     bit_q <= 1'b0;
            else if (set_w) bit_q <= 1'b1;
            else if (clr_w) bit_q <= 1'b0;
         end
         assign pend_flat[g*NPINS + p] = bit_q;
      end
      assign irq_out[g] = |pend_flat[g*NPINS +: NPINS];
   end
endmodule

// File: rtl/irqb_regif.sv
module irqb_regif
   import irqb_pkg::*;
#(
   parameter int NPINS  = 64,
   parameter int NGRP   = 8,
   parameter int ADDR_W = 12,
   parameter int BASE   = 'h800
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [WORD_W-1:0]     bus_wdata,
   input  logic [NGRP*NPINS-1:0] pend_flat,
   output logic [WORD_W-1:0]     bus_rdata,
   output logic                  clr_en,
   output logic [GRP_W-1:0]      clr_grp,
   output logic [WIDX_W-1:0]     clr_word,
   output logic [WORD_W-1:0]     clr_bits
);
   localparam int WORDS    = (NPINS + WORD_W - 1) / WORD_W;
   localparam int SLICE_B  = 64;
   localparam int SPAN     = NGRP * SLICE_B;

   logic [ADDR_W-1:0] off;
   logic [GRP_W-1:0]  grp;
   logic [WIDX_W-1:0] word;
   logic              hit, word_ok;
   logic [WORD_W-1:0] rd_word, rdata_q;

   assign off     = bus_addr - ADDR_W'(BASE);
   assign hit     = (bus_addr >= ADDR_W'(BASE)) && (off < ADDR_W'(SPAN)) &&
                    (bus_addr[1:0] == 2'b00);
   assign grp     = off[6 +: GRP_W];
   assign word    = off[2 +: WIDX_W];
   assign word_ok = (int'(word) < WORDS);

   always_comb begin
      int idx;
      idx     = 0;
      rd_word = '0;
      if (hit && word_ok) begin
         for (int i = 0; i < WORD_W; i++) begin
            idx = int'(word) * WORD_W + i;
            if (idx < NPINS) rd_word[i] = pend_flat[int'(grp) * NPINS + idx];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdata_q <= '0;
      else if (bus_sel && !bus_wr) rdata_q <= rd_word;
   end

   assign bus_rdata = rdata_q;
   assign clr_en    = bus_sel && bus_wr && hit && word_ok;
   assign clr_grp   = grp;
   assign clr_word  = word;
   assign clr_bits  = bus_wdata;
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank
   import irqb_pkg::*;
#(
   parameter int NPINS  = 64,
   parameter int NGRP   = 8,
   parameter int ADDR_W = 12,
   parameter int BASE   = 'h800
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPINS-1:0]        pin_level,
   input  logic [NPINS*MODE_W-1:0] pin_mode,
   input  logic [NPINS*GRP_W-1:0]  pin_grp,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [WORD_W-1:0]       bus_wdata,
   output logic [WORD_W-1:0]       bus_rdata,
   output logic [NGRP-1:0]         irq_out
);
   localparam int MAX_GRP  = 1 << GRP_W;
   localparam int MAX_PINS = WORD_W * (1 << WIDX_W);

   initial begin
      if (NGRP < 1 || NGRP > MAX_GRP)   $fatal(1, "NGRP out of range");
      if (NPINS < 1 || NPINS > MAX_PINS) $fatal(1, "NPINS out of range");
      if (ADDR_W < 10 || (BASE % 64) != 0 || BASE + NGRP * 64 > (1 << ADDR_W))
         $fatal(1, "address window does not fit");
   end

   logic [NPINS-1:0]       pin_event;
   logic [NGRP*NPINS-1:0]  pend_flat;
   logic                   clr_en;
   logic [GRP_W-1:0]       clr_grp;
   logic [WIDX_W-1:0]      clr_word;
   logic [WORD_W-1:0]      clr_bits;

   irqb_detect #(.NPINS(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
      .pin_mode(pin_mode), .pin_event(pin_event));

   irqb_pend #(.NPINS(NPINS), .NGRP(NGRP)) u_pend (
      .clk(clk), .rst_n(rst_n), .pin_event(pin_event), .pin_grp(pin_grp),
      .clr_en(clr_en), .clr_grp(clr_grp), .clr_word(clr_word),
      .clr_bits(clr_bits), .pend_flat(pend_flat), .irq_out(irq_out));

   irqb_regif #(.NPINS(NPINS), .NGRP(NGRP), .ADDR_W(ADDR_W), .BASE(BASE)) u_regif (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_flat(pend_flat),
      .bus_rdata(bus_rdata), .clr_en(clr_en), .clr_grp(clr_grp),
      .clr_word(clr_word), .clr_bits(clr_bits));
endmodule

// File: rtl/irqb_bank_chk.sv
module irqb_bank_chk
   import irqb_pkg::*;
#(
   parameter int NPINS  = 64,
   parameter int NGRP   = 8,
   parameter int ADDR_W = 12,
   parameter int BASE   = 'h800
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NPINS-1:0]       pin_event,
   input logic [NPINS*GRP_W-1:0] pin_grp,
   input logic                   bus_sel,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [WORD_W-1:0]      bus_wdata,
   input logic [WORD_W-1:0]      bus_rdata,
   input logic [NGRP-1:0]        irq_out
);
   logic [NGRP-1:0] grp_hit;

   always_comb begin
      grp_hit = '0;
      for (int g = 0; g < NGRP; g++)
         for (int p = 0; p < NPINS; p++)
            if (pin_event[p] && pin_grp[p*GRP_W +: GRP_W] == GRP_W'(g)) grp_hit[g] = 1'b1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0 && bus_rdata == '0));

   assert_low_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr < ADDR_W'(BASE)) |=> (bus_rdata == '0));

   for (genvar g = 0; g < NGRP; g++) begin : g_chk
      assert_rise_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_out[g]) |-> $past(grp_hit[g]));

      assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_out[g] && !(bus_sel && bus_wr)) |=> irq_out[g]);

      assert_zero_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_out[g] && bus_sel && bus_wr && bus_wdata == '0) |=> irq_out[g]);

      assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         grp_hit[g] |=> irq_out[g]);
   end
endmodule

bind irqb_bank irqb_bank_chk #(.NPINS(NPINS), .NGRP(NGRP), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_event(pin_event), .pin_grp(pin_grp),
   .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

// File: tb/tb_irqb_bank.sv
`timescale 1ns/1ps
module tb_irqb_bank;
   localparam int NP = 64;
   localparam int NG = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_level = '0;
   logic [NP*3-1:0] pin_mode = {NP{3'd7}};
   logic [NP*3-1:0] pin_grp = '0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NG-1:0] irq_out;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irqb_bank dut (.clk(clk), .rst_n(rst_n), .pin_level(pin_level),
      .pin_mode(pin_mode), .pin_grp(pin_grp), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out));

   // behavioural reference model
   bit          m_pend [NG][NP];
   bit          m_prev [NP];
   logic [31:0] m_rd;

   function automatic bit ev_of(int mode, bit lvl, bit prv);
      case (mode)
         2: return lvl;
         3: return !lvl;
         4: return lvl && !prv;
         5: return !lvl && prv;
         6: return lvl != prv;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_pend[g, p]) m_pend[g][p] = 0;
         foreach (m_prev[p]) m_prev[p] = 0;
         m_rd = '0;
      end else begin
         int a, off, g, k;
         bit ok;
         a = int'(bus_addr);
         off = a - 'h800;
         ok = a >= 'h800 && off < NG * 64 && (a % 4) == 0;
         g = ok ? off / 64 : 0;
         k = ok ? (off % 64) / 4 : 0;
         ok = ok && k < (NP + 31) / 32;
         if (bus_sel && !bus_wr) begin
            m_rd = '0;
            if (ok) for (int i = 0; i < 32; i++)
               if (32 * k + i < NP) m_rd[i] = m_pend[g][32 * k + i];
         end
         for (int p = 0; p < NP; p++) begin
            bit e;
            e = ev_of(int'(pin_mode[p*3 +: 3]), pin_level[p], m_prev[p]);
            for (int gg = 0; gg < NG; gg++) begin
               if (bus_sel && bus_wr && ok && gg == g && p / 32 == k && bus_wdata[p % 32])
                  m_pend[gg][p] = 0;
               if (e && int'(pin_grp[p*3 +: 3]) == gg) m_pend[gg][p] = 1;
            end
            m_prev[p] = pin_level[p];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NG-1:0] ei;
         ei = '0;
         foreach (m_pend[g, p]) if (m_pend[g][p]) ei[g] = 1'b1;
         chk("R9 model irq_out", 32'(irq_out), 32'(ei));
         chk("R2 model bus_rdata", bus_rdata, m_rd);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
      @(negedge clk); bus_sel = 0; d = bus_rdata;
   endtask

   task automatic lvl(input int p, input bit v);
      @(negedge clk); pin_level[p] = v;
      @(negedge clk);
   endtask

   task automatic cfg(input int p, input logic [2:0] mode, input logic [2:0] grp);
      @(negedge clk); pin_mode[p*3 +: 3] = mode; pin_grp[p*3 +: 3] = grp;
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 irq_out after reset", 32'(irq_out), 0);
      chk("R1 rdata after reset", bus_rdata, 0);
      rd(12'h800, d); chk("R1 pending word after reset", d, 0);

      // rising edge, pin 5, group 2
      cfg(5, 3'd4, 3'd2);
      chk("R4 no event before edge", 32'(irq_out), 0);
      lvl(5, 1);
      chk("R3 only group 2 line", 32'(irq_out), 32'h04);
      rd(12'h880, d); chk("R2 group 2 word 0 bit 5", d, 32'h20);
      wr(12'h880, 32'h0); chk("R7 zero write keeps bit", 32'(irq_out), 32'h04);
      wr(12'h880, 32'hFFFF_FFDF); chk("R7 other ones keep bit", 32'(irq_out), 32'h04);
      wr(12'h880, 32'h20); chk("R7 write one clears", 32'(irq_out), 0);
      repeat (3) @(negedge clk);
      chk("R6 held level no new edge", 32'(irq_out), 0);

      // falling edge, pin 40, group 7
      lvl(40, 1);
      cfg(40, 3'd5, 3'd7);
      chk("R6 no edge while steady", 32'(irq_out), 0);
      lvl(40, 0);
      rd(12'h9C4, d); chk("R2 group 7 word 1 bit 8", d, 32'h100);
      wr(12'h9C4, 32'h100); chk("R7 clear falling", 32'(irq_out), 0);

      // level high, pin 3, group 0
      cfg(3, 3'd2, 3'd0);
      lvl(3, 1);
      chk("R4 level high sets", 32'(irq_out), 32'h01);
      wr(12'h800, 32'h8);
      rd(12'h800, d); chk("R5 level re-pends after clear", d, 32'h8);
      lvl(3, 0);
      wr(12'h800, 32'h8); chk("R5 released level clears", 32'(irq_out), 0);

      // level low, pin 63, group 1
      cfg(63, 3'd3, 3'd1);
      rd(12'h844, d); chk("R4 level low pin 63", d, 32'h8000_0000);
      cfg(63, 3'd7, 3'd1);
      wr(12'h844, 32'h8000_0000); chk("R4 off mode then clear", 32'(irq_out), 0);

      // both edges, pin 10, group 4; event with clear in same cycle
      cfg(10, 3'd6, 3'd4);
      lvl(10, 1);
      chk("R4 either edge rising", 32'(irq_out), 32'h10);
      @(negedge clk);
      pin_level[10] = 0; bus_sel = 1; bus_wr = 1; bus_addr = 12'h900; bus_wdata = 32'h400;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
      chk("R8 event beats clear", 32'(irq_out), 32'h10);
      wr(12'h900, 32'h400); chk("R8 later clear works", 32'(irq_out), 0);

      // group move, pin 33: group 5 then 6
      cfg(33, 3'd4, 3'd5);
      lvl(33, 1);
      chk("R11 pending in group 5", 32'(irq_out), 32'h20);
      @(negedge clk); pin_level[33] = 0; pin_grp[33*3 +: 3] = 3'd6;
      lvl(33, 1);
      rd(12'h984, d); chk("R11 new group 6 bit 1", d, 32'h2);
      rd(12'h944, d); chk("R11 old group 5 keeps bit 1", d, 32'h2);
      wr(12'h944, 32'h2); wr(12'h984, 32'h2);
      chk("R11 both cleared", 32'(irq_out), 0);

      // disabled modes 0, 1, 7 on pin 20
      cfg(20, 3'd0, 3'd3); lvl(20, 1); lvl(20, 0);
      cfg(20, 3'd1, 3'd3); lvl(20, 1); lvl(20, 0);
      cfg(20, 3'd7, 3'd3); lvl(20, 1); lvl(20, 0);
      chk("R4 modes 0 1 7 silent", 32'(irq_out), 0);

      // OR of two pins in group 2: pins 5 and 50
      lvl(5, 0); lvl(5, 1);
      cfg(50, 3'd4, 3'd2); lvl(50, 1);
      rd(12'h884, d); chk("R2 group 2 word 1 bit 18", d, 32'h4_0000);
      wr(12'h880, 32'h20); chk("R9 one pin left", 32'(irq_out), 32'h04);

      // window edges
      rd(12'h7FC, d); chk("R10 below window reads 0", d, 0);
      rd(12'h888, d); chk("R10 word 2 reads 0", d, 0);
      rd(12'h886, d); chk("R10 misaligned reads 0", d, 0);
      wr(12'h084, 32'hFFFF_FFFF); wr(12'h886, 32'hFFFF_FFFF);
      wr(12'hA84, 32'hFFFF_FFFF); wr(12'h88C, 32'hFFFF_FFFF);
      chk("R10 stray writes no effect", 32'(irq_out), 32'h04);
      wr(12'h884, 32'h4_0000); chk("R9 last pin cleared", 32'(irq_out), 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule